// File: doc/BRIEF.md
# Logarithmic Reciprocal, Reciprocal-Root and Power Unit

This block evaluates three special functions on a signed 32-bit fixed-point operand with 16 fraction bits (Q16.16): the reciprocal 1/x, the reciprocal square root 1/sqrt(|x|), and the power |x|^n. The operand is split into a sign, a 5-bit exponent (index of the leading one) and a 16-bit fraction. It is then mapped to a base-2 logarithm with the linear rule log2(1+f) ≈ f. The function is applied in the log domain and the result is mapped back with 2^f ≈ 1+f. The reciprocal negates the log value. The reciprocal root also halves it with an arithmetic shift right by one bit. The power function sends the log value to a multiplier outside the block, which holds the exponent n, and feeds the returned product to the back conversion.

The unit is pipelined with three register stages: log conversion, log-domain operation and back conversion with range checks. It accepts one operation per cycle. A power operation waits in the first stage until the outside multiplier answers, and it holds off new input while it waits. The log value is signed, 22 bits wide, with 6 integer bits and 16 fraction bits (two's complement). The product port uses the same format.

Top module: `lsfu`

## Requirements
- R1: After reset, out_vld_o and mul_req_o are 0 and in_rdy_o is 1.
- R2: Configuration 2'b00 (bit 1 clear, bit 0 clear) gives the reciprocal, and the output carries the input's sign. The result is exact for powers of two (2.0 gives 0x00008000, -2.0 gives 0xFFFF8000) and within 15 % of the true value elsewhere in range.
- R3: Configuration bit 0 set with bit 1 clear gives the reciprocal square root of |x|, and the input sign is ignored. The result is exact for even powers of two (4.0 and -4.0 give 0x00008000; raw 1 gives 0x01000000) and within 15 % elsewhere.
- R4: Configuration bit 1 set selects power, whatever bit 0 holds. The block drives mul_log_o with log2|x| (4.0 gives 0x020000) and, once mul_vld_i is high, takes the result from 2^mul_prod_i. The result is exact when the product is an integer and within 30 % for |n| ≤ 2 elsewhere.
- R5: A zero operand raises out_err_o. For reciprocal and reciprocal root the output is 0x7FFFFFFF. For power the output is 0 and no multiplier request is made.
- R6: While a power operation waits in the first stage for mul_vld_i, in_rdy_o is 0, mul_req_o is 1 and mul_log_o stays stable.
- R7: A non-power operation accepted at a clock edge shows out_vld_o after the third following edge. Back-to-back operations give back-to-back results in order.
- R8: When the integer part of the final log value is below -16, the output is 0 and out_uflow_o is 1. A valid, error-free result that has not underflowed is never 0.
- R9: When the integer part of the final log value exceeds 14, the output saturates to 0x7FFFFFFF, or to 0x80000001 for a negative reciprocal (raw 2 and raw -2).
- R10: out_err_o and out_uflow_o are 0 whenever out_vld_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Operand valid |
| in_rdy_o | output | 1 | Operand accepted this cycle when high |
| in_data_i | input | 32 | Operand, signed Q16.16 |
| in_cfg_i | input | 2 | Bit 0: halve log (root), bit 1: use multiplier product (power) |
| mul_req_o | output | 1 | Request to the outside multiplier |
| mul_log_o | output | 22 | Log2 of the operand magnitude, signed Q6.16 |
| mul_vld_i | input | 1 | Product valid, one pulse per request |
| mul_prod_i | input | 22 | n times the log value, signed Q6.16 |
| out_vld_o | output | 1 | Result valid |
| out_data_o | output | 32 | Result, signed Q16.16 |
| out_err_o | output | 1 | Zero operand seen |
| out_uflow_o | output | 1 | Result too small, flushed to zero |

## Verification
The assertions assume that mul_vld_i pulses once, and only in answer to a pending request, with a product that belongs to the log value being held. The bench's multiplier model is a registered product that raises valid for exactly one cycle per request. The bench changes the exponent only after a power operation has left the first stage. Random operands are kept in ranges where the result neither saturates nor underflows and where truncation stays far below the tolerance. The saturation, underflow and zero cases are driven only as directed vectors with exact expected values.

// File: rtl/lsfu_pkg.sv
package lsfu_pkg;
  parameter int DATA_W = 32;
  parameter int FRAC_W = 16;
  parameter int EXP_W  = $clog2(DATA_W);
  parameter int K_W    = EXP_W + 1;
  parameter int LOG_W  = K_W + FRAC_W;
  parameter int CFG_W  = 2;
  parameter int CFG_HALVE = 0;
  parameter int CFG_POW   = 1;

  typedef enum logic [1:0] {OP_INV, OP_ISQRT, OP_POW} op_e;

  typedef struct packed {
    op_e              op;
    logic             sgn;
    logic             zero;
    logic [LOG_W-1:0] val;
  } stage_t;
endpackage

// File: rtl/lsfu_msb.sv
module lsfu_msb #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lsfu_log.sv
module lsfu_log import lsfu_pkg::*; (
  input  logic [DATA_W-1:0] data_i,
  output logic              sgn_o,
  output logic              zero_o,
  output logic [LOG_W-1:0]  log_o
);
  logic [DATA_W-1:0] mag, norm;
  logic [EXP_W-1:0]  lead;
  logic [FRAC_W-1:0] frac;

  assign sgn_o  = data_i[DATA_W-1];
  assign zero_o = (data_i == '0);
  assign mag    = sgn_o ? (~data_i + DATA_W'(1)) : data_i;

  lsfu_msb #(.W(DATA_W), .IW(EXP_W)) u_msb (.vec_i(mag), .idx_o(lead));

  assign norm = mag << (EXP_W'(DATA_W-1) - lead);
  assign frac = norm[DATA_W-2 -: FRAC_W];
  // integer part = lead - FRAC_W (Q16.16 weight), fraction taken as log2(1+f) ~ f
  assign log_o = {({1'b0, lead} - K_W'(FRAC_W)), frac};
endmodule

// File: rtl/lsfu_exp.sv
module lsfu_exp import lsfu_pkg::*; (
  input  logic [LOG_W-1:0]  log_i,
  input  logic              sgn_i,
  input  logic              zero_i,
  input  logic              pow_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              uflow_o
);
  localparam int MANT_W = FRAC_W + 1;
  localparam logic signed [K_W-1:0] K_HI = K_W'(DATA_W - 1 - MANT_W);
  localparam logic signed [K_W-1:0] K_LO = K_W'(-FRAC_W);
  localparam logic [DATA_W-1:0] SAT = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [K_W-1:0] k;
  logic [K_W-1:0]        nk;
  logic [DATA_W-1:0]     mant, mag;
  logic                  ovf, uf;

  assign k    = log_i[LOG_W-1:FRAC_W];
  assign nk   = -k;
  assign mant = DATA_W'({1'b1, log_i[FRAC_W-1:0]});

  always_comb begin
    mag = '0;
    ovf = 1'b0;
    uf  = 1'b0;
    if (k > K_HI)       ovf = 1'b1;
    else if (k < K_LO)  uf  = 1'b1;
    else if (!k[K_W-1]) mag = mant << k[EXP_W-1:0];
    else                mag = mant >> nk;
  end

  always_comb begin
    err_o   = 1'b0;
    uflow_o = 1'b0;
    if (zero_i) begin
      err_o  = 1'b1;
      data_o = pow_i ? '0 : SAT;
    end else if (ovf) begin
      data_o = sgn_i ? -SAT : SAT;
    end else if (uf) begin
      uflow_o = 1'b1;
      data_o  = '0;
    end else begin
      data_o = sgn_i ? -mag : mag;
    end
  end
endmodule

// File: rtl/lsfu.sv
module lsfu import lsfu_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  output logic              in_rdy_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [CFG_W-1:0]  in_cfg_i,
  output logic              mul_req_o,
  output logic [LOG_W-1:0]  mul_log_o,
  input  logic              mul_vld_i,
  input  logic [LOG_W-1:0]  mul_prod_i,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_err_o,
  output logic              out_uflow_o
);
  stage_t s0, s1_q, s2_d, s2_q;
  logic   s1_vld_q, s2_vld_q, stall;
  logic   l_sgn, l_zero;
  logic [LOG_W-1:0] l_val;
  logic signed [LOG_W-1:0] neg_val;
  logic [DATA_W-1:0] x_data;
  logic x_err, x_uf;

  lsfu_log u_log (.data_i(in_data_i), .sgn_o(l_sgn), .zero_o(l_zero), .log_o(l_val));

  always_comb begin
    s0.op   = in_cfg_i[CFG_POW]   ? OP_POW :
              in_cfg_i[CFG_HALVE] ? OP_ISQRT : OP_INV;
    s0.sgn  = l_sgn;
    s0.zero = l_zero;
    s0.val  = l_val;
  end

  // power op parks in stage 1 until the product returns
  assign mul_req_o = s1_vld_q && (s1_q.op == OP_POW) && !s1_q.zero;
  assign mul_log_o = s1_q.val;
  assign stall     = mul_req_o && !mul_vld_i;
  assign in_rdy_o  = !stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_q     <= '0;
    end else if (!stall) begin
      s1_vld_q <= in_vld_i;
      s1_q     <= s0;
    end
  end

  assign neg_val = -$signed(s1_q.val);

  always_comb begin
    s2_d = s1_q;
    unique case (s1_q.op)
      OP_POW:   s2_d.val = mul_prod_i;
      OP_ISQRT: s2_d.val = neg_val >>> 1;
      default:  s2_d.val = neg_val;
    endcase
    s2_d.sgn = s1_q.sgn && (s1_q.op == OP_INV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_q <= 1'b0;
      s2_q     <= '0;
    end else begin
      s2_vld_q <= s1_vld_q && !stall;
      s2_q     <= s2_d;
    end
  end

  lsfu_exp u_exp (
    .log_i  (s2_q.val),
    .sgn_i  (s2_q.sgn),
    .zero_i (s2_q.zero),
    .pow_i  (s2_q.op == OP_POW),
    .data_o (x_data),
    .err_o  (x_err),
    .uflow_o(x_uf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o   <= 1'b0;
      out_data_o  <= '0;
      out_err_o   <= 1'b0;
      out_uflow_o <= 1'b0;
    end else begin
      out_vld_o   <= s2_vld_q;
      out_data_o  <= x_data;
      out_err_o   <= s2_vld_q && x_err;
      out_uflow_o <= s2_vld_q && x_uf;
    end
  end
endmodule

// File: rtl/lsfu_chk.sv
module lsfu_chk import lsfu_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_vld_i,
  input logic              in_rdy_o,
  input logic [CFG_W-1:0]  in_cfg_i,
  input logic              mul_req_o,
  input logic [LOG_W-1:0]  mul_log_o,
  input logic              mul_vld_i,
  input logic              out_vld_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_err_o,
  input logic              out_uflow_o
);
  localparam logic [DATA_W-1:0] SAT = {1'b0, {(DATA_W-1){1'b1}}};

  a_r6_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_req_o && !mul_vld_i |=> mul_req_o && $stable(mul_log_o));

  a_r6_no_accept_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_req_o && !mul_vld_i |-> !in_rdy_o);

  a_r7_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i && in_rdy_o && !in_cfg_i[CFG_POW] |-> ##3 out_vld_o);

  a_r5_error_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && out_err_o |-> (out_data_o == SAT || out_data_o == '0));

  a_r8_flush_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && out_uflow_o |-> out_data_o == '0 && !out_err_o);

  a_r8_nonzero_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && !out_uflow_o && !out_err_o |-> out_data_o != '0);

  a_r10_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> !out_err_o && !out_uflow_o);
endmodule

bind lsfu lsfu_chk u_chk (.*);

// File: tb/lsfu_test.sv
module lsfu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        in_rdy;
  logic [31:0] in_data = '0;
  logic [1:0]  in_cfg = '0;
  logic        mul_req;
  logic [21:0] mul_log;
  logic        mul_vld;
  logic [21:0] mul_prod;
  logic        out_vld;
  logic [31:0] out_data;
  logic        out_err;
  logic        out_uf;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int pow_n = 256;   // exponent n in Q8.8, held by the outside multiplier

  typedef struct {
    logic [31:0] x;
    logic [1:0]  cfg;
    int          n;
    int          stamp;
    bit          exact;
    logic [31:0] want;
    bit          werr;
    bit          wuf;
    string       rq;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  lsfu uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_vld_i(in_vld), .in_rdy_o(in_rdy), .in_data_i(in_data), .in_cfg_i(in_cfg),
    .mul_req_o(mul_req), .mul_log_o(mul_log), .mul_vld_i(mul_vld), .mul_prod_i(mul_prod),
    .out_vld_o(out_vld), .out_data_o(out_data), .out_err_o(out_err), .out_uflow_o(out_uf)
  );

  // outside multiplier: registered product, one valid pulse per request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_vld  <= 1'b0;
      mul_prod <= '0;
    end else begin
      longint t;
      t = (longint'($signed(mul_log)) * longint'(pow_n)) >>> 8;
      if (t > 64'sd2097151) t = 64'sd2097151;
      if (t < -64'sd2097152) t = -64'sd2097152;
      mul_vld  <= mul_req && !mul_vld;
      mul_prod <= t[21:0];
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, want);
    end
  endtask

  function automatic real rabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  function automatic real ref_raw(input logic [31:0] x, input logic [1:0] cfg, input int n);
    real v, r;
    v = rabs($itor($signed(x))) / 65536.0;
    if (cfg[1])      r = $pow(v, $itor(n) / 256.0);
    else if (cfg[0]) r = 1.0 / $sqrt(v);
    else begin
      r = 1.0 / v;
      if (x[31]) r = -r;
    end
    return r * 65536.0;
  endfunction

  // result monitor
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", "result with nothing pending", longint'(out_data), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (!e.cfg[1])
          chk(cyc - e.stamp == 3, "R7", "latency", longint'(cyc - e.stamp), 3);
        if (e.exact) begin
          chk(out_data == e.want, e.rq, "data", longint'(out_data), longint'(e.want));
          chk(out_err == e.werr && out_uf == e.wuf, e.rq, "err/uflow flags",
              longint'({out_err, out_uf}), longint'({e.werr, e.wuf}));
        end else begin
          real r, a, tol;
          r   = ref_raw(e.x, e.cfg, e.n);
          a   = $itor($signed(out_data));
          tol = e.cfg[1] ? 0.30 : 0.15;
          chk(rabs(a - r) <= tol * rabs(r) + 4.0 && !out_err && !out_uf, e.rq,
              $sformatf("approx x=0x%08h cfg=%0d", e.x, e.cfg),
              longint'($signed(out_data)), longint'($rtoi(r)));
        end
      end
    end
  end

  task automatic issue(input logic [31:0] x, input logic [1:0] cfg, input bit exact,
                       input logic [31:0] want, input bit werr, input bit wuf, input string rq);
    exp_t e;
    in_vld  = 1'b1;
    in_data = x;
    in_cfg  = cfg;
    forever begin
      @(negedge clk);
      if (in_rdy) begin
        e.x = x; e.cfg = cfg; e.n = pow_n; e.stamp = cyc; e.exact = exact;
        e.want = want; e.werr = werr; e.wuf = wuf; e.rq = rq;
        q.push_back(e);
        break;
      end
    end
    @(posedge clk);
    #2;
    in_vld = 1'b0;
  endtask

  task automatic issue_pow(input logic [31:0] x, input int n, input bit exact,
                           input logic [31:0] want, input bit werr, input bit wuf,
                           input string rq);
    pow_n = n;
    issue(x, 2'b10, exact, want, werr, wuf, rq);
    repeat (4) @(posedge clk);
    #2;
  endtask

  function automatic logic [31:0] rnd_mag(input int lo, input int hi);
    int p;
    logic [31:0] m;
    p = $urandom_range(hi, lo);
    m = (32'd1 << p) | ($urandom() & ((32'd1 << p) - 1));
    return m;
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_vld && !mul_req && in_rdy, "R1", "reset outputs",
        longint'({out_vld, mul_req, in_rdy}), 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_vld && !mul_req && in_rdy, "R1", "after release",
        longint'({out_vld, mul_req, in_rdy}), 1);
    @(posedge clk); #2;

    // reciprocal and root, directed
    issue(32'h0002_0000, 2'b00, 1, 32'h0000_8000, 0, 0, "R2");
    issue(32'hFFFE_0000, 2'b00, 1, 32'hFFFF_8000, 0, 0, "R2");
    issue(32'h0004_0000, 2'b01, 1, 32'h0000_8000, 0, 0, "R3");
    issue(32'hFFFC_0000, 2'b01, 1, 32'h0000_8000, 0, 0, "R3");
    issue(32'h0000_0001, 2'b01, 1, 32'h0100_0000, 0, 0, "R3");
    issue(32'h0000_0002, 2'b00, 1, 32'h7FFF_FFFF, 0, 0, "R9");
    issue(32'hFFFF_FFFE, 2'b00, 1, 32'h8000_0001, 0, 0, "R9");
    issue(32'h0000_0000, 2'b00, 1, 32'h7FFF_FFFF, 1, 0, "R5");
    issue(32'h0000_0000, 2'b01, 1, 32'h7FFF_FFFF, 1, 0, "R5");
    repeat (5) @(posedge clk); #2;

    // power, directed
    pow_n = 512;
    issue(32'h0004_0000, 2'b10, 1, 32'h0010_0000, 0, 0, "R4");
    @(negedge clk);
    chk(!in_rdy && mul_req && mul_log == 22'h02_0000, "R6", "waiting for product",
        longint'({in_rdy, mul_req, mul_log}), longint'({1'b0, 1'b1, 22'h02_0000}));
    repeat (4) @(posedge clk); #2;
    issue_pow(32'h0002_0000, 512, 1, 32'h0004_0000, 0, 0, "R4");
    pow_n = 512;
    issue(32'h0002_0000, 2'b11, 1, 32'h0004_0000, 0, 0, "R4");
    repeat (4) @(posedge clk); #2;
    issue_pow(32'h0003_0000, 0, 1, 32'h0001_0000, 0, 0, "R4");
    issue_pow(32'h0002_0000, -256, 1, 32'h0000_8000, 0, 0, "R4");
    issue_pow(32'h0004_0000, 2048, 1, 32'h7FFF_FFFF, 0, 0, "R9");
    issue_pow(32'h0000_4000, 4096, 1, 32'h0000_0000, 0, 1, "R8");
    pow_n = 256;
    issue(32'h0000_0000, 2'b10, 1, 32'h0000_0000, 1, 0, "R5");
    @(negedge clk);
    chk(!mul_req && in_rdy, "R5", "no request on zero power",
        longint'({mul_req, in_rdy}), 1);
    repeat (5) @(posedge clk); #2;

    // random reciprocal stream, one per cycle
    for (int i = 0; i < 40; i++) begin
      logic [31:0] m;
      m = rnd_mag(2, 24);
      if ($urandom_range(1, 0) == 1) m = -m;
      issue(m, 2'b00, 0, '0, 0, 0, "R2");
    end
    // random root stream
    for (int i = 0; i < 40; i++) begin
      logic [31:0] m;
      m = rnd_mag(0, 30);
      issue(m, 2'b01, 0, '0, 0, 0, "R3");
    end
    repeat (5) @(posedge clk); #2;
    // random power
    for (int i = 0; i < 20; i++) begin
      issue_pow(rnd_mag(12, 20), int'($urandom_range(1024, 0)) - 512, 0, '0, 0, 0, "R4");
    end

    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R7", "all results delivered", longint'(q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule